// File: doc/BRIEF.md
# PROM Image Programming Sequencer

This block burns a complete image of 16-bit words into a serial PROM that sits behind a simple memory-write bus. On a start pulse it first reads the PROM control register, sets the write-enable bit and writes the register back. It then waits a long settle interval and writes every image word in ascending order, with a fixed pacing gap after each word. Finally it clears write-enable with a second read-modify-write and waits another settle interval before it reports done. All waits are given in milliseconds and converted to clock cycles from `CLK_HZ`, so a bench can shorten them by lowering that parameter. The image should be checked by a separate CRC unit before start is raised.

The image comes from a zero-latency word-read port. The block drives `img_idx`, and `img_data` must return that word within the same cycle. The block samples `img_data` in the cycle before it raises a word request. Every bus transfer is a valid/ready handshake. The block raises `bus_valid` and keeps address, data and direction unchanged until the cycle in which `bus_ready` is high. A read returns its data on `bus_rdata` in that same accepting cycle. The bus may stall any request for any number of cycles, and all waits count from the accepting edge.

While the sequencer runs, three one-cycle progress milestones mark the quarter, half and three-quarter points of the image. An abort input stops the burst early, but write-enable is always cleared before the block returns to idle.

Top module: `prom_burn_seq`

## Requirements
- R1: While reset is asserted, and after it is released, busy, done, milestone and bus_valid are 0. A request is never presented while busy is 0.
- R2: After an accepted start (start high while idle), the first transfer is a read of CTRL_ADDR. The second transfer is a write to CTRL_ADDR of the read value with bit WE_BIT set and every other bit unchanged. Both come before any word write.
- R3: Between the accepting edge of the enable write and the first word request there are exactly SETTLE cycles with no request; the word request appears in the next cycle.
- R4: Word i of the image is written to BASE_ADDR + 2*i with the value img_data returned for img_idx = i. The words go out in ascending order, i = 0 to WORDS-1, each exactly once.
- R5: Every word write, the last one included, is followed by exactly GAP idle cycles after its accepting edge before the next request.
- R6: After the final gap the block reads CTRL_ADDR and writes back the value with bit WE_BIT cleared and every other bit kept. It then waits SETTLE idle cycles and pulses done for one cycle, in the same cycle that busy falls.
- R7: milestone pulses for one cycle, in the first cycle of the request for word WORDS/4, WORDS/2 and 3*WORDS/4. milestone_code is 1, 2 and 3 for those three points. There are no other pulses.
- R8: While bus_valid is high and bus_ready is low, bus_valid stays high and bus_addr, bus_wdata and bus_we hold their values in the next cycle.
- R9: start is ignored while busy. The running sequence continues unchanged and no second enable read occurs.
- R10: An abort during the enable phase, the settle or the word burst does three things in order. It lets the outstanding request finish. It then performs the read and the write-enable-clearing write of R6 at once: 1 cycle after a word acceptance that coincides with the abort, or 1 cycle after an abort during a wait. It then returns to idle with no final settle and no done. An abort while idle has no effect.
- R11: An abort that arrives once the clearing read has started is ignored. The sequence ends with the settle and done of R6.
- R12: SETTLE = max(1, CLK_HZ*SETTLE_MS/1000) cycles and GAP = max(1, CLK_HZ*GAP_MS/1000) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, taken only while idle |
| abort | input | 1 | Stop the burst and clear write-enable |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse on normal completion |
| milestone | output | 1 | One-cycle progress pulse |
| milestone_code | output | 2 | 1 quarter, 2 half, 3 three quarters |
| img_idx | output | $clog2(WORDS+1) | Index of the image word wanted |
| img_data | input | DW | Image word for img_idx, same cycle |
| bus_valid | output | 1 | Bus request present |
| bus_ready | input | 1 | Bus accepts the request this cycle |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | AW | Byte address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid in the accepting cycle |

## Verification
The case of interest is an abort that arrives in the same cycle the bus accepts a word write. The bench provokes it by raising abort at the sampling point where its bus model raises ready for word five. The word must count as written, and the clearing read must follow one cycle later with no gap and no further word, then idle without done. A second run aborts one cycle into a gap instead, where the read follows two cycles after the acceptance. This separates the two paths.

// File: rtl/prom_burn_pkg.sv
package prom_burn_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD_ON,
    ST_WR_ON,
    ST_SETTLE_ON,
    ST_WORD,
    ST_GAP,
    ST_RD_OFF,
    ST_WR_OFF,
    ST_SETTLE_OFF
  } burn_state_t;

  // Convert a millisecond interval to clock cycles, never below one cycle.
  function automatic longint unsigned ms_to_cycles(input longint unsigned hz,
                                                   input longint unsigned ms);
    longint unsigned c;
    c = (hz * ms) / 1000;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/prom_burn_timer.sv
module prom_burn_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/prom_burn_progress.sv
module prom_burn_progress #(
  parameter int WORDS = 64,
  parameter int IW    = 7
) (
  input  logic          word_first,
  input  logic [IW-1:0] idx,
  output logic          milestone,
  output logic [1:0]    milestone_code
);
  logic [2:0] hit;

  for (genvar k = 0; k < 3; k++) begin : g_thr
    localparam int THR = ((k + 1) * WORDS) / 4;
    assign hit[k] = word_first && (idx == IW'(THR));
  end

  always_comb begin
    milestone_code = 2'd0;
    if (hit[0])      milestone_code = 2'd1;
    else if (hit[1]) milestone_code = 2'd2;
    else if (hit[2]) milestone_code = 2'd3;
  end

  assign milestone = |hit;
endmodule

// File: rtl/prom_burn_seq.sv
module prom_burn_seq
  import prom_burn_pkg::*;
#(
  parameter longint unsigned CLK_HZ    = 100_000_000,
  parameter int              WORDS     = 64,
  parameter int              AW        = 16,
  parameter int              DW        = 16,
  parameter logic [AW-1:0]   BASE_ADDR = 16'h1000,
  parameter logic [AW-1:0]   CTRL_ADDR = 16'h0040,
  parameter int              WE_BIT    = 4,
  parameter int              SETTLE_MS = 500,
  parameter int              GAP_MS    = 20,
  localparam int             IW        = $clog2(WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          abort,
  output logic          busy,
  output logic          done,
  output logic          milestone,
  output logic [1:0]    milestone_code,
  output logic [IW-1:0] img_idx,
  input  logic [DW-1:0] img_data,
  output logic          bus_valid,
  input  logic          bus_ready,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata
);
  localparam longint unsigned SETTLE_CYC = ms_to_cycles(CLK_HZ, longint'(SETTLE_MS));
  localparam longint unsigned GAP_CYC    = ms_to_cycles(CLK_HZ, longint'(GAP_MS));
  localparam longint unsigned MAX_CYC    = (SETTLE_CYC > GAP_CYC) ? SETTLE_CYC : GAP_CYC;
  localparam int              TW         = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
  localparam logic [TW-1:0]   SETTLE_LD  = TW'(SETTLE_CYC - 1);
  localparam logic [TW-1:0]   GAP_LD     = TW'(GAP_CYC - 1);
  localparam logic [DW-1:0]   WE_MASK    = DW'(1) << WE_BIT;

  burn_state_t   state, state_n;
  logic [IW-1:0] idx;
  logic          abort_pend, aborting, word_first, done_q;
  logic          we_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          hs, abort_any, in_run_phase;
  logic          t_load, t_expired;
  logic [TW-1:0] t_val;

  assign hs           = bus_valid & bus_ready;
  assign abort_any    = abort | abort_pend;
  assign in_run_phase = (state == ST_RD_ON) || (state == ST_WR_ON) || (state == ST_SETTLE_ON) ||
                        (state == ST_WORD)  || (state == ST_GAP);

  // Next-state decision.
  always_comb begin
    state_n = state;
    unique case (state)
      ST_IDLE:       if (start) state_n = ST_RD_ON;
      ST_RD_ON:      if (hs) state_n = abort_any ? ST_RD_OFF : ST_WR_ON;
      ST_WR_ON:      if (hs) state_n = abort_any ? ST_RD_OFF : ST_SETTLE_ON;
      ST_SETTLE_ON:  if (abort_any) state_n = ST_RD_OFF;
                     else if (t_expired) state_n = ST_WORD;
      ST_WORD:       if (hs) state_n = abort_any ? ST_RD_OFF : ST_GAP;
      ST_GAP:        if (abort_any) state_n = ST_RD_OFF;
                     else if (t_expired) state_n = (idx == IW'(WORDS)) ? ST_RD_OFF : ST_WORD;
      ST_RD_OFF:     if (hs) state_n = ST_WR_OFF;
      ST_WR_OFF:     if (hs) state_n = aborting ? ST_IDLE : ST_SETTLE_OFF;
      ST_SETTLE_OFF: if (t_expired) state_n = ST_IDLE;
      default:       state_n = ST_IDLE;
    endcase
  end

  assign t_load = (state_n != state) &&
                  ((state_n == ST_SETTLE_ON) || (state_n == ST_GAP) || (state_n == ST_SETTLE_OFF));
  assign t_val  = (state_n == ST_GAP) ? GAP_LD : SETTLE_LD;

  prom_burn_timer #(.W(TW)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      idx        <= '0;
      abort_pend <= 1'b0;
      aborting   <= 1'b0;
      word_first <= 1'b0;
      done_q     <= 1'b0;
      we_q       <= 1'b0;
      addr_q     <= '0;
      wdata_q    <= '0;
    end else begin
      state      <= state_n;
      done_q     <= (state == ST_SETTLE_OFF) && (state_n == ST_IDLE);
      word_first <= (state_n == ST_WORD) && (state != ST_WORD);
      if (in_run_phase && abort) abort_pend <= 1'b1;

      unique case (state)
        ST_IDLE: if (start) begin
          idx        <= '0;
          addr_q     <= CTRL_ADDR;
          we_q       <= 1'b0;
          aborting   <= 1'b0;
          abort_pend <= 1'b0;
        end
        ST_RD_ON: if (hs && state_n == ST_WR_ON) begin
          we_q    <= 1'b1;
          wdata_q <= bus_rdata | WE_MASK;
        end
        ST_WORD: if (hs) idx <= idx + 1'b1;
        ST_RD_OFF: if (hs) begin
          we_q    <= 1'b1;
          wdata_q <= bus_rdata & ~WE_MASK;
        end
        default: ;
      endcase

      if (state_n == ST_WORD && state != ST_WORD) begin
        addr_q  <= BASE_ADDR + (AW'(idx) << 1);
        wdata_q <= img_data;
        we_q    <= 1'b1;
      end
      if (state_n == ST_RD_OFF && state != ST_RD_OFF) begin
        addr_q     <= CTRL_ADDR;
        we_q       <= 1'b0;
        abort_pend <= 1'b0;
        aborting   <= abort_any;
      end
    end
  end

  prom_burn_progress #(.WORDS(WORDS), .IW(IW)) progress_i (
    .word_first     (word_first),
    .idx            (idx),
    .milestone      (milestone),
    .milestone_code (milestone_code)
  );

  assign bus_valid = (state == ST_RD_ON) || (state == ST_WR_ON) || (state == ST_WORD) ||
                     (state == ST_RD_OFF) || (state == ST_WR_OFF);
  assign bus_we    = we_q;
  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;
  assign busy      = (state != ST_IDLE);
  assign done      = done_q;
  assign img_idx   = idx;
endmodule

// File: rtl/prom_burn_seq_chk.sv
module prom_burn_seq_chk #(
  parameter int            AW        = 16,
  parameter int            DW        = 16,
  parameter logic [AW-1:0] CTRL_ADDR = 16'h0040
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          milestone,
  input logic          bus_valid,
  input logic          bus_ready,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata
);
  // R8: a stalled request is held unchanged
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_we));

  // R1: no request outside a running sequence
  p_valid_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> busy);

  // R2: a sequence opens with a read of the control register
  p_first_ctrl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> bus_valid && !bus_we && (bus_addr == CTRL_ADDR));

  // R6: done lasts one cycle and coincides with idle
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R7: milestones only mark an image word write
  p_ms_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    milestone |-> bus_valid && bus_we && (bus_addr != CTRL_ADDR));
endmodule

bind prom_burn_seq prom_burn_seq_chk #(.AW(AW), .DW(DW), .CTRL_ADDR(CTRL_ADDR)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .milestone (milestone),
  .bus_valid (bus_valid),
  .bus_ready (bus_ready),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata)
);

// File: tb/prom_burn_seq_tb.sv
module prom_burn_seq_tb_top;
  localparam int          CLK_PERIOD = 10;
  localparam int          W     = 8;
  localparam int          IW    = $clog2(W + 1);
  localparam logic [15:0] BASE  = 16'h1000;
  localparam logic [15:0] CTRL  = 16'h0040;
  localparam logic [15:0] MASK  = 16'h0010;  // WE_BIT = 4
  localparam int          S     = 50;        // 100 Hz * 500 ms / 1000
  localparam int          G     = 2;         // 100 Hz * 20 ms / 1000
  // {ready latency[39:32], control init[31:16], image seed[15:0]}
  localparam logic [39:0] VEC [3] = '{40'h00_0000_A5C3, 40'h02_8001_1234, 40'h05_0F10_FFFF};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, abort = 1'b0;
  logic busy, done, milestone, bus_valid, bus_ready = 1'b0, bus_we;
  logic [1:0]    milestone_code;
  logic [IW-1:0] img_idx;
  logic [15:0]   img_data, bus_addr, bus_wdata, bus_rdata;

  int          latency = 0;
  logic [15:0] ctrl_init = '0, img_seed = '0, ctrl_mem = '0;
  int checks = 0, bad = 0, mon_checks = 0, mon_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [15:0] img_word(input logic [15:0] s, input int i);
    return s ^ (16'(i) * 16'h3B07);
  endfunction

  assign img_data  = img_word(img_seed, int'(img_idx));
  assign bus_rdata = ctrl_mem;

  prom_burn_seq #(.CLK_HZ(100), .WORDS(W), .AW(16), .DW(16), .BASE_ADDR(BASE),
                  .CTRL_ADDR(CTRL), .WE_BIT(4), .SETTLE_MS(500), .GAP_MS(20)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .busy(busy), .done(done),
    .milestone(milestone), .milestone_code(milestone_code), .img_idx(img_idx),
    .img_data(img_data), .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // Bus model and monitor: everything sampled at the falling edge.
  int          cyc = 0, ntr = 0, nwords = 0, nrd = 0, nms = 0, ndone = 0, done_cyc = 0;
  int          lat_ctr = 0, first_cur = 0;
  bit          in_req = 0, prev_pend = 0;
  logic [15:0] prev_addr, prev_data;
  logic        prev_we;
  logic        t_we   [256];
  logic [15:0] t_addr [256];
  logic [15:0] t_data [256];
  int          t_hs   [256];
  int          t_first[256];
  logic [1:0]  m_code [64];
  logic [15:0] m_addr [64];

  always @(negedge clk) begin
    cyc++;
    if (!busy) ctrl_mem = ctrl_init;
    if (prev_pend) begin
      mon_checks++;
      if (!bus_valid || bus_addr != prev_addr || bus_wdata != prev_data || bus_we != prev_we) begin
        mon_bad++;
        $display("FAIL R8 stalled request changed: actual=%h/%h expected=%h/%h",
                 bus_addr, bus_wdata, prev_addr, prev_data);
      end
    end
    if (bus_valid) begin
      if (!in_req) begin in_req = 1; lat_ctr = 0; first_cur = cyc; end
      else lat_ctr++;
      bus_ready = (lat_ctr >= latency);
    end else begin
      bus_ready = 1'b0;
    end
    prev_pend = bus_valid && !bus_ready;
    prev_addr = bus_addr; prev_data = bus_wdata; prev_we = bus_we;
    if (bus_valid && bus_ready && ntr < 256) begin
      t_we[ntr] = bus_we; t_addr[ntr] = bus_addr; t_data[ntr] = bus_wdata;
      t_hs[ntr] = cyc; t_first[ntr] = first_cur;
      if (bus_we && bus_addr == CTRL) ctrl_mem = bus_wdata;
      if (bus_we && bus_addr != CTRL) nwords++;
      if (!bus_we) nrd++;
      ntr++;
      in_req = 0;
    end
    if (milestone && nms < 64) begin
      m_code[nms] = milestone_code; m_addr[nms] = bus_addr; nms++;
    end
    if (done) begin ndone++; done_cyc = cyc; end
    if (cyc == 150000) begin
      $display("FAIL watchdog expired: actual=%0d expected=<150000", cyc);
      $display("test done: total=%0d bad=%0d", checks + mon_checks + 1, bad + mon_bad + 1);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk); #1;
      if (!busy) return;
    end
    chk("R1", "watchdog: sequence never finished", 1, 0);
  endtask

  // inj: 0 none, 1 start mid-burst, 2 abort in gap after word 2,
  //      3 abort with acceptance of word 5, 4 abort during clearing
  task automatic run(input logic [39:0] v, input int inj);
    int b, mb, db, w0, r0;
    latency = int'(v[39:32]); ctrl_init = v[31:16]; img_seed = v[15:0];
    repeat (2) @(negedge clk);
    #1; b = ntr; mb = nms; db = ndone; w0 = nwords; r0 = nrd;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    case (inj)
      1: begin wait (nwords >= w0 + 3); @(negedge clk) start = 1'b1; @(negedge clk) start = 1'b0; end
      2: begin wait (nwords >= w0 + 2); @(negedge clk) abort = 1'b1; @(negedge clk) abort = 1'b0; end
      3: begin wait (nwords >= w0 + 5); abort = 1'b1; @(negedge clk) abort = 1'b0; end
      4: begin wait (nrd >= r0 + 2); abort = 1'b1; @(negedge clk) abort = 1'b0; end
      default: ;
    endcase
    wait_idle();
    @(negedge clk); #1;
    if (inj == 2 || inj == 3) begin
      int k;
      k = (inj == 2) ? 2 : 5;
      chk("R10", "words written before abort", nwords - w0, k);
      chk("R10", "transactions after abort", ntr - b, k + 4);
      chk("R10", "clearing read address", {t_we[b+k+2], t_addr[b+k+2]}, {1'b0, CTRL});
      chk("R10", "clearing read delay", t_first[b+k+2] - t_hs[b+k+1], (inj == 2) ? 2 : 1);
      chk("R10", "clearing write data", t_data[b+k+3], ctrl_init & ~MASK);
      chk("R10", "no done after abort", ndone - db, 0);
    end else begin
      chk(inj == 1 ? "R9" : "R4", "transaction count", ntr - b, W + 4);
      chk("R9", "enable reads per run", nrd - r0, 2);
      chk("R2", "first is ctrl read", {t_we[b], t_addr[b]}, {1'b0, CTRL});
      chk("R2", "enable write", {t_we[b+1], t_addr[b+1], t_data[b+1]}, {1'b1, CTRL, ctrl_init | MASK});
      chk("R3", "settle before first word", t_first[b+2] - t_hs[b+1], S + 1);
      for (int i = 0; i < W; i++) begin
        chk("R4", $sformatf("word %0d addr", i), t_addr[b+2+i], BASE + 16'(2 * i));
        chk("R4", $sformatf("word %0d data", i), t_data[b+2+i], img_word(img_seed, i));
        chk("R5", $sformatf("gap after word %0d", i), t_first[b+3+i] - t_hs[b+2+i], G + 1);
      end
      chk("R6", "clearing read", {t_we[b+W+2], t_addr[b+W+2]}, {1'b0, CTRL});
      chk("R6", "clearing write", {t_we[b+W+3], t_addr[b+W+3], t_data[b+W+3]},
          {1'b1, CTRL, ctrl_init & ~MASK});
      chk(inj == 4 ? "R11" : "R6", "done count", ndone - db, 1);
      chk("R6", "final settle", done_cyc - t_hs[b+W+3], S + 1);
      chk("R7", "milestone count", nms - mb, 3);
      for (int k = 0; k < 3; k++) begin
        chk("R7", $sformatf("milestone %0d code", k), m_code[mb+k], k + 1);
        chk("R7", $sformatf("milestone %0d word", k), m_addr[mb+k], BASE + 16'(2 * (k + 1) * W / 4));
      end
    end
  endtask

  initial begin
    int b;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "busy in reset", busy, 0);
    chk("R1", "bus_valid in reset", bus_valid, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1", "done after reset", done, 0);
    chk("R1", "milestone after reset", milestone, 0);
    chk("R1", "busy after reset", busy, 0);

    // R12 timing (S, G) is checked inside every run through R3, R5 and R6.
    for (int v = 0; v < 3; v++) run(VEC[v], 0);

    // R10: abort while idle has no effect
    #1; b = ntr;
    @(negedge clk) abort = 1'b1;
    @(negedge clk) abort = 1'b0;
    repeat (5) @(negedge clk);
    #1;
    chk("R10", "idle abort busy", busy, 0);
    chk("R10", "idle abort transactions", ntr - b, 0);

    run(VEC[1], 1);   // R9
    run(VEC[0], 2);   // R10 abort in a gap
    run(VEC[2], 3);   // R10 abort with a word acceptance
    run(VEC[1], 4);   // R11

    $display("test done: total=%0d bad=%0d", checks + mon_checks, bad + mon_bad);
    $finish;
  end
endmodule